// File: doc/BRIEF.md
# Half/Single Precision Lane Converter

This block converts a vector register of `LANES` 32-bit lanes between IEEE binary32 and IEEE binary16. It has two directions, chosen by a one-bit operation select.

When narrowing, two binary32 source vectors are rounded to binary16. Their results are interleaved into one output vector: in each 32-bit lane, the low halfword comes from source A and the high halfword comes from source B.

When widening, the halfwords of source A are expanded exactly to binary32. The even-indexed halfwords go to the low result vector and the odd-indexed halfwords go to the high result vector, which gives a vector pair.

The conversion is purely lane-local. Both result vectors are registered, so a result appears one clock after its operands. Flags are not produced.

Top module: `fp_lane_conv`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first operation is clocked in, `res_lo` and `res_hi` are all zeros.
- R2: With `op`=0 (narrow), halfword 2i of `res_lo` (bits 32i+15..32i) is the binary16 form of `src_a` word i, and halfword 2i+1 (bits 32i+31..32i+16) is the binary16 form of `src_b` word i. `res_hi` is zero.
- R3: With `op`=1 (widen), word i of `res_lo` is the binary32 form of `src_a` halfword 2i, and word i of `res_hi` is the binary32 form of `src_a` halfword 2i+1. `src_b` has no effect.
- R4: Narrowing rounds to nearest, with ties going to the even mantissa. This also applies to ties in the denormal range; for example, 2^-25 becomes +0.
- R5: A finite binary32 value whose magnitude rounds to 65520 or above narrows to an infinity of the same sign (0x7C00 or 0xFC00). An infinite input narrows to the infinity of the same sign.
- R6: Magnitudes below 2^-14 narrow to binary16 denormals (exponent field 0) or to zero. Binary32 zeros and denormals give a zero of the same sign.
- R7: A binary32 NaN narrows to a quiet NaN of the same sign. Its exponent field is 31, mantissa bit 9 is 1, and mantissa bits 8..0 are taken from binary32 mantissa bits 21..13.
- R8: A binary16 NaN widens to a quiet NaN of the same sign. Its exponent field is 255, mantissa bit 22 is 1, bits 21..13 are the binary16 mantissa bits 8..0, and the low bits are zero.
- R9: Widening is exact. Binary16 denormals become normalized binary32 values, and signed zeros and infinities keep their sign.
- R10: Each result appears on the rising clock edge that samples its operands, so there is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 1 | 0 = narrow binary32 to binary16, 1 = widen binary16 to binary32 |
| src_a | input | 32*LANES | First source vector |
| src_b | input | 32*LANES | Second source vector (used only when narrowing) |
| res_lo | output | 32*LANES | Narrowed vector, or even-index widened vector |
| res_hi | output | 32*LANES | Zero when narrowing, or odd-index widened vector |

## Verification
Nothing is held from one operation to the next, so a wrong internal state can only show up as a wrong lane value. It is visible on the very next clock edge.

A swapped lane or a wrong even/odd split shows up as values appearing in the wrong halfword. The stimulus therefore rotates distinct operands through every lane position.

Rounding, overflow, denormal and NaN faults affect only the values that reach those ranges. Each of those ranges has its own table entries.

// File: rtl/fp_lane_conv.sv
module fp_lane_conv #(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op,
  input  logic [32*LANES-1:0]   src_a,
  input  logic [32*LANES-1:0]   src_b,
  output logic [32*LANES-1:0]   res_lo,
  output logic [32*LANES-1:0]   res_hi
);
  localparam int W = 32 * LANES;

  function automatic logic [15:0] to_half(input logic [31:0] x);
    logic        s;
    logic [7:0]  e;
    logic [7:0]  he;
    logic [22:0] m;
    logic [49:0] t;
    logic [15:0] r;
    int          sh;
    s = x[31];
    e = x[30:23];
    m = x[22:0];
    r = {s, 15'b0};
    t = '0;
    sh = 0;
    he = 8'd0;
    if (e == 8'hff) begin
      if (m != 23'd0) r = {s, 5'h1f, 1'b1, m[21:13]};
      else            r = {s, 5'h1f, 10'b0};
    end else if (e >= 8'd143) begin
      r = {s, 5'h1f, 10'b0};
    end else if (e >= 8'd113) begin
      he = e - 8'd112;
      r = {s, he[4:0], m[22:13]};
      if (m[12] && ((|m[11:0]) || m[13])) r = r + 16'd1;
    end else if (e != 8'd0) begin
      sh = 126 - int'(e);
      if (sh > 26) sh = 26;
      t = {1'b1, m, 26'b0} >> sh;
      r = {s, 5'b0, t[35:26]};
      if (t[25] && ((|t[24:0]) || t[26])) r = r + 16'd1;
    end
    return r;
  endfunction

  function automatic logic [31:0] to_single(input logic [15:0] h);
    logic        s;
    logic [4:0]  e;
    logic [9:0]  m;
    logic [9:0]  nm;
    logic [7:0]  fe;
    logic [31:0] r;
    int          p;
    s = h[15];
    e = h[14:10];
    m = h[9:0];
    p = 0;
    nm = '0;
    fe = '0;
    if (e == 5'h1f) begin
      if (m != 10'd0) r = {s, 8'hff, 1'b1, m[8:0], 13'b0};
      else            r = {s, 8'hff, 23'b0};
    end else if (e == 5'd0) begin
      if (m == 10'd0) r = {s, 31'b0};
      else begin
        for (int k = 0; k < 10; k++) if (m[k]) p = k;
        nm = m << (10 - p);
        fe = 8'(p + 103);
        r = {s, fe, nm, 13'b0};
      end
    end else begin
      fe = {3'b0, e} + 8'd112;
      r = {s, fe, m, 13'b0};
    end
    return r;
  endfunction

  logic [W-1:0] nxt_lo, nxt_hi;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wire [31:0] wa = src_a[32*i +: 32];
    wire [31:0] wb = src_b[32*i +: 32];
    assign nxt_lo[32*i +: 32] = op ? to_single(wa[15:0])
                                   : {to_half(wb), to_half(wa)};
    assign nxt_hi[32*i +: 32] = op ? to_single(wa[31:16]) : 32'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_lo <= '0;
      res_hi <= '0;
    end else begin
      res_lo <= nxt_lo;
      res_hi <= nxt_hi;
    end
  end

  // R2
  narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op |=> res_hi == '0);

  // R9
  widen_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op && src_a[14:0] == 15'h7c00 |=> res_lo[31:0] == {$past(src_a[15]), 31'h7f800000});

  // R7
  narrow_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op && src_a[30:23] == 8'hff && src_a[22:0] != 23'd0
    |=> res_lo[14:9] == 6'h3f && res_lo[15] == $past(src_a[31]));

  // R6
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op && src_a[30:23] == 8'd0 |=> res_lo[15:0] == {$past(src_a[31]), 15'b0});

  // R8
  widen_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op && src_a[14:10] == 5'h1f && src_a[9:0] != 10'd0
    |=> res_lo[30:22] == 9'h1ff && res_lo[12:0] == 13'd0);
endmodule

// File: tb/fp_lane_conv_tb.sv
module fp_lane_conv_tb;
  localparam int LANES = 4;
  localparam int W = 32 * LANES;
  localparam int NN = 15;
  localparam int NW = 13;

  // narrowing table: input binary32 -> expected binary16
  localparam logic [31:0] N_IN [NN] = '{
    32'h3f800000, 32'hc0000000, 32'h477fe000,  // R2 plain values
    32'h477ff000, 32'hc77ff000, 32'h7f7fffff,  // R5 overflow
    32'h7fc00001, 32'hff800100,                // R7 NaN
    32'h33800000, 32'h33000000, 32'h33400000,  // R6 / R4 denormal range
    32'h3f801000, 32'h3f803000,                // R4 ties
    32'h80000001, 32'h38000000};               // R6
  localparam logic [15:0] N_OUT [NN] = '{
    16'h3c00, 16'hc000, 16'h7bff,
    16'h7c00, 16'hfc00, 16'h7c00,
    16'h7e00, 16'hfe00,
    16'h0001, 16'h0000, 16'h0001,
    16'h3c00, 16'h3c02,
    16'h8000, 16'h0200};

  // widening table: input binary16 -> expected binary32
  localparam logic [15:0] W_IN [NW] = '{
    16'h3c00, 16'hc000, 16'h7bff,              // R3 plain values
    16'h0001, 16'h03ff, 16'h8001, 16'h0200,    // R9 denormals
    16'h7c00, 16'hfc00, 16'h0000, 16'h8000,    // R9 inf / zero
    16'h7d01, 16'hfe00};                       // R8 NaN
  localparam logic [31:0] W_OUT [NW] = '{
    32'h3f800000, 32'hc0000000, 32'h477fe000,
    32'h33800000, 32'h387fc000, 32'hb3800000, 32'h38000000,
    32'h7f800000, 32'hff800000, 32'h00000000, 32'h80000000,
    32'h7fe02000, 32'hffc00000};

  logic clk = 0;
  logic rst_n = 0;
  logic op = 0;
  logic [W-1:0] src_a = '0, src_b = '0;
  logic [W-1:0] res_lo, res_hi;
  int checks = 0, errors = 0;
  logic [W-1:0] exp_lo, exp_hi;

  always #2 clk = ~clk;

  fp_lane_conv #(.LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .src_a(src_a), .src_b(src_b),
    .res_lo(res_lo), .res_hi(res_hi));

  task automatic check(input string req, input logic [W-1:0] lo, input logic [W-1:0] hi);
    checks++;
    if (res_lo !== lo || res_hi !== hi) begin
      errors++;
      $display("FAIL %s lo=%h hi=%h expected lo=%h hi=%h", req, res_lo, res_hi, lo, hi);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1 reset", '0, '0);
        src_a = {LANES{32'h3f800000}};
        @(negedge clk);
        check("R1 held in reset", '0, '0);
        rst_n = 1;
        check("R1 after release", '0, '0);

        for (int k = 0; k < NN; k++) begin
          op = 0;
          for (int i = 0; i < LANES; i++) begin
            src_a[32*i +: 32] = N_IN[(k + i) % NN];
            src_b[32*i +: 32] = N_IN[(k + i + 7) % NN];
            exp_lo[32*i +: 32] = {N_OUT[(k + i + 7) % NN], N_OUT[(k + i) % NN]};
          end
          // R10: unchanged until the edge
          @(posedge clk); #1;
          check("R2/R4/R5/R6/R7 narrow", exp_lo, '0);
        end

        for (int k = 0; k < NW; k++) begin
          op = 1;
          src_b = {LANES{32'hdeadbeef}};  // R3: src_b ignored
          for (int i = 0; i < LANES; i++) begin
            src_a[32*i +: 16]      = W_IN[(k + 2*i) % NW];
            src_a[32*i + 16 +: 16] = W_IN[(k + 2*i + 1) % NW];
            exp_lo[32*i +: 32] = W_OUT[(k + 2*i) % NW];
            exp_hi[32*i +: 32] = W_OUT[(k + 2*i + 1) % NW];
          end
          @(posedge clk); #1;
          check("R3/R8/R9 widen", exp_lo, exp_hi);
        end

        // R10: change inputs between edges, output holds until next edge
        @(negedge clk);
        op = 0;
        src_a = {LANES{32'h3f800000}};
        src_b = {LANES{32'hc0000000}};
        #1;
        check("R10 hold before edge", exp_lo, exp_hi);
        @(posedge clk); #1;
        check("R10 one-cycle update", {LANES{32'hc0003c00}}, '0);

        // R1: reset mid-run clears results
        @(negedge clk);
        rst_n = 0;
        @(posedge clk); #1;
        check("R1 mid-run reset", '0, '0);
        rst_n = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule